// File: doc/BRIEF.md
# Cascadable Reload Timer Pair with Compare Output

This block holds two down-counting timers of W bits each, a low timer and a high timer, which software reaches through a small register bus. Each timer has a run bit and a clock-gate bit. It also has a reload value, a compare value and a counter that software can only read. Each timer takes one count tick per cycle at most, from an external tick input. A preset strobe copies the reload value into the counter. When a tick would take the counter below zero, the counter is reloaded instead and a one-cycle underflow pulse goes out. When a tick brings the counter to the compare value, the timer's output pin toggles and its sticky interrupt flag is set. Software clears the flag by writing 1 to it.

A join bit in the low timer's control register turns the pair into one timer of 2W bits. In this mode the low timer alone receives ticks, and its borrow steps the high timer. The high timer's own tick, run and clock-gate inputs then have no effect. One preset, written through the low timer, loads both halves. Compare and underflow then work on the full 2W-bit value and report on the low timer's outputs. A read of the low counter byte does not freeze the high byte. To get a consistent wide value, software stops the low timer before reading.

Top module: `tmr_pair`

Register map. Address bit 2 selects the timer (0 = low, 1 = high). Address bits 1:0 select the register: 0 = control, 1 = reload, 2 = compare, 3 = counter. The control bits are: bit 0 run, bit 1 preset (write only), bit 2 clock gate, bit 3 interrupt flag (write 1 to clear), bit 4 join (low timer only, reads 0 on the high timer).

## Requirements
- R1: After reset, every reload register reads 0xFF, every compare register reads 0x00, every counter reads 0xFF, both control registers read 0x00, and irq, tout and unf are all 0.
- R2: While a timer's clock-gate bit (control bit 2) is 0, its tick input does not change its counter, even with the run bit set.
- R3: While the run bit (control bit 0) and the clock-gate bit are both 1, each cycle with the timer's tick high lowers the counter by one. While the run bit is 0, the counter holds.
- R4: A tick that finds the counter at zero reloads it from the reload register instead of lowering it, and unf for that timer is 1 for the single following cycle.
- R5: Writing control with bit 1 set loads the reload value into the counter in the next cycle. A stopped timer keeps that value, and a running timer counts down from it on the following ticks. Bit 1 always reads back as 0, and writing control with bit 1 clear loads nothing.
- R6: Writes to the counter address (offset 3) are ignored, and the counter keeps its value.
- R7: A tick that leaves the counter equal to the compare register toggles that timer's tout and sets its irq flag (control bit 3). The flag stays set until control is written with bit 3 set. A preset never counts as a match.
- R8: With join (low control bit 4) set, the two counters form one 2W-bit counter with the low timer as the low half. The high half changes only on a borrow from the low half, and the high timer's tick, run and clock-gate bits are ignored. An underflow from 0 reloads both halves and pulses unf[0], and unf[1] stays 0.
- R9: With join set, a preset written to the low control register loads both halves from the two reload registers, and a preset written to the high control register has no effect.
- R10: With join set, a match is detected against the 2W-bit compare value {high compare, low compare}. The match drives irq[0] and tout[0], while irq[1] and tout[1] are not set by the joined counter.
- R11: The reload and compare registers read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address: bit 2 timer, bits 1:0 register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data for bus_addr, combinational |
| tick | input | 2 | Count tick per timer, bit 0 low, bit 1 high |
| irq | output | 2 | Sticky compare-match interrupt flag per timer |
| tout | output | 2 | Timer output, toggles on each compare match |
| unf | output | 2 | One-cycle underflow pulse per timer |

## Verification
On every cycle, the bound checker confirms four things: an underflow pulse only follows a tick, the high timer never pulses unf while joined, tout only moves when the irq flag is set, and the flag holds until a write clears it. It also confirms that neither counter moves in a cycle with no tick and no bus write. The exact counter values are left to the bench's scenarios and its per-cycle reference model. So are the reload-on-underflow value, the preset priority over a tick, the ignored high preset and the borrow into the high half when joined, and the match on the full wide compare value.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
   // control register bit positions (decoded by software)
   localparam int CTRL_RUN    = 0;
   localparam int CTRL_PRESET = 1;
   localparam int CTRL_CLKEN  = 2;
   localparam int CTRL_FLAG   = 3;
   localparam int CTRL_JOIN   = 4;
   localparam int CTRL_BITS   = 5;

   // register offsets within one timer's window
   localparam logic [1:0] OFS_CTRL   = 2'd0;
   localparam logic [1:0] OFS_RELOAD = 2'd1;
   localparam logic [1:0] OFS_CMP    = 2'd2;
   localparam logic [1:0] OFS_COUNT  = 2'd3;
endpackage

// File: rtl/tmr_slice.sv
`timescale 1ns/1ps
module tmr_slice #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         dec,
   input  logic [W-1:0] reload,
   output logic [W-1:0] cnt,
   output logic         zero
);
   // load has priority over a decrement in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '1;
      else if (load)
         cnt <= reload;
      else if (dec)
         cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/tmr_event.sv
`timescale 1ns/1ps
module tmr_event (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic clr,
   output logic flag,
   output logic tout
);
   // a set in the same cycle as a clear wins
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag <= 1'b0;
         tout <= 1'b0;
      end else begin
         if (hit)
            flag <= 1'b1;
         else if (clr)
            flag <= 1'b0;
         if (hit)
            tout <= ~tout;
      end
   end
endmodule

// File: rtl/tmr_pair.sv
`timescale 1ns/1ps
module tmr_pair
   import tmr_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [2:0]   bus_addr,
   input  logic         bus_wr,
   input  logic [W-1:0] bus_wdata,
   output logic [W-1:0] bus_rdata,
   input  logic [1:0]   tick,
   output logic [1:0]   irq,
   output logic [1:0]   tout,
   output logic [1:0]   unf
);
   localparam int NT = 2;
   localparam int DW = NT * W;

   if (W < CTRL_BITS) begin : g_width_bad
      $error("tmr_pair: W must hold all control bits");
   end

   logic                   joined;
   logic [NT-1:0]          run, clken, sel_ctrl, pre, clr;
   logic [NT-1:0]          step, load, dec, zero, hit, ufl;
   logic [NT-1:0][W-1:0]   rld, cmpv, cnt_q, nxt;

   // per-timer registers, counter slice and event logic
   for (genvar i = 0; i < NT; i++) begin : g_tmr
      localparam logic TID = (i == 1);
      logic         wr_mine;
      logic         run_r, ce_r;
      logic [W-1:0] rld_r, cmp_r;

      assign wr_mine     = bus_wr && (bus_addr[2] == TID);
      assign sel_ctrl[i] = wr_mine && (bus_addr[1:0] == OFS_CTRL);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            run_r <= 1'b0;
            ce_r  <= 1'b0;
            rld_r <= '1;
            cmp_r <= '0;
         end else begin
            if (sel_ctrl[i]) begin
               run_r <= bus_wdata[CTRL_RUN];
               ce_r  <= bus_wdata[CTRL_CLKEN];
            end
            if (wr_mine && bus_addr[1:0] == OFS_RELOAD)
               rld_r <= bus_wdata;
            if (wr_mine && bus_addr[1:0] == OFS_CMP)
               cmp_r <= bus_wdata;
         end
      end

      assign run[i]   = run_r;
      assign clken[i] = ce_r;
      assign rld[i]   = rld_r;
      assign cmpv[i]  = cmp_r;
      assign pre[i]   = sel_ctrl[i] && bus_wdata[CTRL_PRESET];
      assign clr[i]   = sel_ctrl[i] && bus_wdata[CTRL_FLAG];
      assign step[i]  = run_r && ce_r && tick[i];
      assign nxt[i]   = zero[i] ? rld_r : cnt_q[i] - 1'b1;

      tmr_slice #(.W(W)) u_slice (
         .clk    (clk),
         .rst_n  (rst_n),
         .load   (load[i]),
         .dec    (dec[i]),
         .reload (rld_r),
         .cnt    (cnt_q[i]),
         .zero   (zero[i])
      );

      tmr_event u_evt (
         .clk  (clk),
         .rst_n(rst_n),
         .hit  (hit[i]),
         .clr  (clr[i]),
         .flag (irq[i]),
         .tout (tout[i])
      );
   end

   // join bit lives in the low timer's control register
   always_ff @(posedge clk) begin
      if (!rst_n)
         joined <= 1'b0;
      else if (sel_ctrl[0])
         joined <= bus_wdata[CTRL_JOIN];
   end

   // wide view of the cascade
   logic [DW-1:0] wide_cnt, wide_rld, wide_cmp, wide_nxt;
   logic          wide_uf;

   assign wide_cnt = cnt_q;
   assign wide_rld = rld;
   assign wide_cmp = cmpv;
   assign wide_uf  = step[0] && zero[0] && zero[1];
   assign wide_nxt = wide_uf ? wide_rld : wide_cnt - 1'b1;

   // count control: joined cascade or two independent timers
   always_comb begin
      if (joined) begin
         load   = {NT{pre[0] | wide_uf}};
         dec[0] = step[0] && !wide_uf;
         dec[1] = step[0] && zero[0] && !wide_uf;
         hit    = {1'b0, step[0] && !pre[0] && (wide_nxt == wide_cmp)};
         ufl    = {1'b0, wide_uf && !pre[0]};
      end else begin
         load = pre | (step & zero);
         dec  = step & ~zero;
         for (int k = 0; k < NT; k++)
            hit[k] = step[k] && !pre[k] && (nxt[k] == cmpv[k]);
         ufl  = step & zero & ~pre;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         unf <= '0;
      else
         unf <= ufl;
   end

   // read mux
   logic         tsel;
   logic [W-1:0] ctl_view;

   assign tsel = bus_addr[2];

   always_comb begin
      ctl_view             = '0;
      ctl_view[CTRL_RUN]   = run[tsel];
      ctl_view[CTRL_CLKEN] = clken[tsel];
      ctl_view[CTRL_FLAG]  = irq[tsel];
      ctl_view[CTRL_JOIN]  = joined && !tsel;
      case (bus_addr[1:0])
         OFS_CTRL:   bus_rdata = ctl_view;
         OFS_RELOAD: bus_rdata = rld[tsel];
         OFS_CMP:    bus_rdata = cmpv[tsel];
         default:    bus_rdata = cnt_q[tsel];
      endcase
   end
endmodule

// File: rtl/tmr_pair_chk.sv
`timescale 1ns/1ps
module tmr_pair_chk #(
   parameter int W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic [2:0]         bus_addr,
   input logic               bus_wr,
   input logic               clr_bit,
   input logic [1:0]         tick,
   input logic [1:0]         irq,
   input logic [1:0]         tout,
   input logic [1:0]         unf,
   input logic               joined,
   input logic [1:0][W-1:0]  cnt
);
   // R4
   unf_lo_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unf[0] |-> $past(tick[0]));

   // R4
   unf_hi_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unf[1] |-> $past(tick[1]));

   // R8
   unf_hi_joined_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(joined) |-> !unf[1]);

   // R7
   tout_lo_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tout[0]) |-> irq[0]);

   // R7
   tout_hi_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tout[1]) |-> irq[1]);

   // R7
   irq_lo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq[0] && !(bus_wr && bus_addr == 3'd0 && clr_bit) |=> irq[0]);

   // R7
   irq_hi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq[1] && !(bus_wr && bus_addr == 3'd4 && clr_bit) |=> irq[1]);

   // R2 R3
   cnt_lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick[0] && !bus_wr |=> $stable(cnt[0]));

   // R3 R8
   cnt_hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick[0] && !tick[1] && !bus_wr |=> $stable(cnt[1]));
endmodule

bind tmr_pair tmr_pair_chk #(.W(W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .bus_addr(bus_addr),
   .bus_wr  (bus_wr),
   .clr_bit (bus_wdata[tmr_pkg::CTRL_FLAG]),
   .tick    (tick),
   .irq     (irq),
   .tout    (tout),
   .unf     (unf),
   .joined  (joined),
   .cnt     (cnt_q)
);

// File: tb/tmr_pair_test.sv
`timescale 1ns/1ps
module tmr_pair_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [1:0] tick = '0;
   logic [1:0] irq, tout, unf;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   tmr_pair #(.W(8)) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick),
      .irq(irq), .tout(tout), .unf(unf)
   );

   // ---------------- behavioural reference model ----------------
   int m_cnt[2], m_rld[2], m_cmp[2];
   bit m_run[2], m_ce[2], m_irq[2], m_tout[2], m_unf[2], m_join;

   always @(posedge clk) begin
      int a, d, v, r, c;
      bit pre[2], st[2], h[2], u[2];
      if (!rst_n) begin
         for (int i = 0; i < 2; i++) begin
            m_cnt[i] = 255; m_rld[i] = 255; m_cmp[i] = 0;
            m_run[i] = 0; m_ce[i] = 0; m_irq[i] = 0; m_tout[i] = 0; m_unf[i] = 0;
         end
         m_join = 0;
      end else begin
         a = int'(bus_addr);
         d = int'(bus_wdata);
         pre[0] = bus_wr && a == 0 && d[1];
         pre[1] = bus_wr && a == 4 && d[1];
         for (int i = 0; i < 2; i++) begin
            st[i] = m_run[i] && m_ce[i] && tick[i];
            h[i] = 0; u[i] = 0;
         end
         if (m_join) begin
            v = m_cnt[1] * 256 + m_cnt[0];
            r = m_rld[1] * 256 + m_rld[0];
            c = m_cmp[1] * 256 + m_cmp[0];
            if (pre[0]) v = r;
            else if (st[0]) begin
               if (v == 0) begin v = r; u[0] = 1; end
               else v = v - 1;
               h[0] = (v == c);
            end
            m_cnt[0] = v % 256;
            m_cnt[1] = v / 256;
         end else begin
            for (int i = 0; i < 2; i++) begin
               if (pre[i]) m_cnt[i] = m_rld[i];
               else if (st[i]) begin
                  if (m_cnt[i] == 0) begin m_cnt[i] = m_rld[i]; u[i] = 1; end
                  else m_cnt[i] = m_cnt[i] - 1;
                  h[i] = (m_cnt[i] == m_cmp[i]);
               end
            end
         end
         if (bus_wr) begin
            case (a)
               0: begin m_run[0] = d[0]; m_ce[0] = d[2]; m_join = d[4]; if (d[3]) m_irq[0] = 0; end
               1: m_rld[0] = d;
               2: m_cmp[0] = d;
               4: begin m_run[1] = d[0]; m_ce[1] = d[2]; if (d[3]) m_irq[1] = 0; end
               5: m_rld[1] = d;
               6: m_cmp[1] = d;
               default: ;
            endcase
         end
         for (int i = 0; i < 2; i++) begin
            if (h[i]) begin m_irq[i] = 1; m_tout[i] = ~m_tout[i]; end
            m_unf[i] = u[i];
         end
      end
   end

   function automatic int mread(int a);
      int t;
      t = a / 4;
      case (a % 4)
         0: return int'(m_run[t]) | (int'(m_ce[t]) << 2) | (int'(m_irq[t]) << 3)
                   | ((t == 0) ? (int'(m_join) << 4) : 0);
         1: return m_rld[t];
         2: return m_cmp[t];
         default: return m_cnt[t];
      endcase
   endfunction

   // per-cycle comparison of the registered outputs (R4, R7, R8, R10)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if ({irq, tout, unf} !== {m_irq[1], m_irq[0], m_tout[1], m_tout[0], m_unf[1], m_unf[0]}) begin
            errors++;
            $display("FAIL R4 R7 R8 R10 outputs: irq/tout/unf actual %b %b %b expected %b%b %b%b %b%b",
                     irq, tout, unf, m_irq[1], m_irq[0], m_tout[1], m_tout[0], m_unf[1], m_unf[0]);
         end
      end
   end

   // ---------------- tasks ----------------
   task automatic wr(input int a, input int d);
      @(negedge clk);
      bus_addr = 3'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic tk(input logic [1:0] m);
      @(negedge clk);
      tick = m;
      @(negedge clk);
      tick = 2'b00;
   endtask

   task automatic rdx(input int a, input int exp, input string tag);
      bus_addr = 3'(a);
      #1;
      checks++;
      if (int'(bus_rdata) != exp || int'(bus_rdata) != mread(a)) begin
         errors++;
         $display("FAIL %s read addr %0d: actual %02h expected %02h (model %02h)",
                  tag, a, bus_rdata, exp, mread(a));
      end
   endtask

   task automatic rdm(input int a, input string tag);
      bus_addr = 3'(a);
      #1;
      checks++;
      if (int'(bus_rdata) != mread(a)) begin
         errors++;
         $display("FAIL %s read addr %0d: actual %02h expected %02h", tag, a, bus_rdata, mread(a));
      end
   endtask

   task automatic bitx(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   // ---------------- scenarios ----------------
   initial begin
      logic t0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rdx(0, 8'h00, "R1"); rdx(1, 8'hFF, "R1"); rdx(2, 8'h00, "R1"); rdx(3, 8'hFF, "R1");
      rdx(4, 8'h00, "R1"); rdx(7, 8'hFF, "R1");
      bitx(irq[0] | tout[0] | unf[0], 1'b0, "R1 outputs");

      // R11 readback
      wr(1, 5); wr(2, 3);
      rdx(1, 5, "R11"); rdx(2, 3, "R11");

      // R6 counter write ignored
      wr(3, 8'h12);
      rdx(3, 8'hFF, "R6");

      // R5 preset while stopped, bit reads 0, zero write harmless
      wr(0, 8'h02);
      rdx(3, 5, "R5"); rdx(0, 0, "R5");
      wr(0, 8'h00);
      rdx(3, 5, "R5");

      // R3 stopped timer holds
      repeat (3) tk(2'b01);
      rdx(3, 5, "R3");

      // R2 clock gate closed
      wr(0, 8'h01);
      repeat (3) tk(2'b01);
      rdx(3, 5, "R2");

      // R3 counting, R7 match at 3
      wr(0, 8'h05);
      repeat (2) tk(2'b01);
      rdx(3, 3, "R3");
      bitx(irq[0], 1'b1, "R7 irq set"); bitx(tout[0], 1'b1, "R7 tout toggled");

      // R4 underflow reload
      repeat (3) tk(2'b01);
      rdx(3, 0, "R4");
      tk(2'b01);
      bitx(unf[0], 1'b1, "R4 pulse");
      @(negedge clk);
      bitx(unf[0], 1'b0, "R4 pulse ends");
      rdx(3, 5, "R4");

      // R7 write-1 clear
      wr(0, 8'h0D);
      bitx(irq[0], 1'b0, "R7 clear"); bitx(tout[0], 1'b1, "R7 tout holds");

      // R5 preset while running
      repeat (2) tk(2'b01);
      wr(0, 8'h07);
      rdx(3, 5, "R5");
      tk(2'b01);
      rdx(3, 4, "R5");

      // independent high timer
      wr(5, 3); wr(6, 1); wr(4, 8'h07);
      repeat (2) tk(2'b10);
      rdx(7, 1, "R3");
      bitx(tout[1], 1'b1, "R7 high");

      // R8 R9 R10 joined mode
      wr(0, 8'h00);
      wr(1, 2); wr(5, 1); wr(2, 0); wr(6, 1);
      wr(0, 8'h15);
      wr(0, 8'h17);
      rdx(3, 2, "R9"); rdx(7, 1, "R9");
      repeat (3) tk(2'b10);
      rdx(7, 1, "R8"); rdx(3, 2, "R8");
      wr(5, 9);
      wr(4, 8'h07);
      rdx(7, 1, "R9");
      wr(0, 8'h1D);
      wr(4, 8'h0D);
      t0 = tout[0];
      repeat (2) tk(2'b01);
      rdx(3, 0, "R10"); rdx(7, 1, "R10");
      bitx(irq[0], 1'b1, "R10 wide match");
      bitx(tout[0], ~t0, "R10 tout");
      bitx(irq[1], 1'b0, "R10 high quiet");
      tk(2'b01);
      rdx(3, 8'hFF, "R8"); rdx(7, 0, "R8");
      repeat (255) tk(2'b01);
      rdx(3, 0, "R8"); rdx(7, 0, "R8");
      tk(2'b01);
      bitx(unf[0], 1'b1, "R8 wide underflow");
      bitx(unf[1], 1'b0, "R8 high no pulse");
      rdx(3, 2, "R8"); rdx(7, 9, "R8");

      // mixed random ticks in both modes, model compared every cycle
      wr(1, 7); wr(2, 4); wr(5, 6); wr(6, 2);
      wr(0, 8'h05); wr(4, 8'h05);
      for (int n = 0; n < 400; n++) begin
         @(negedge clk);
         tick = 2'($urandom);
         if (n == 200) begin
            bus_addr = 3'd0; bus_wdata = 8'h17; bus_wr = 1'b1;
         end else begin
            bus_wr = 1'b0;
         end
      end
      @(negedge clk);
      tick = 2'b00; bus_wr = 1'b0;
      @(negedge clk);
      for (int a = 0; a < 8; a++) rdm(a, "R3 R8");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule